// File: doc/BRIEF.md
# External SRAM Bus-Cycle Sequencer

This block converts single read and write requests from an on-chip requester into timed bus cycles on an external SRAM-style memory area. A request is accepted with a valid/ready handshake only while the block is idle. The area is decoded from the three most significant address bits, compared with a configured area code. On a hit the block drives an active-low chip select, a read strobe that serves as the memory output enable, eight active-low byte write strobes, an active-low bus-start pulse, the address, and the write data with its output enable.

Every part of the cycle is timed from configuration inputs: address setup before chip select, the delay from chip select to the strobe, the strobe width (one cycle plus 0 to 25 inserted waits), the delay from strobe release to chip-select release, and the address hold after chip select. When waits are programmed, an active-low ready input from the memory can stretch the strobe. In burst-ROM mode a read becomes a fixed number of beats separated by a programmable pitch, with the address stepping by the bus width. A one-cycle done pulse closes every request. Configuration is expected to stay static while a request is in flight.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A request is a hit only when `req_addr[28:26]` equals `cfg_area`. A miss is accepted, pulses `done` in the cycle after acceptance, and leaves every bus strobe and the chip select inactive.
- R2: `req_ready` is high only while idle and `done` is low. `done` is a single-cycle pulse and arrives in the cycle after the last hold cycle.
- R3: After acceptance the address is driven with `bus_cs_n` high for `cfg_setup` cycles (0 to 7) before chip select falls.
- R4: Chip select is low for `cfg_rd_dly` (reads) or `cfg_wr_dly` (writes) cycles before the strobe falls. The delay of the other direction has no effect.
- R5: With ready low, the strobe is low for 1 + min(`cfg_wait`, 25) cycles, so any `cfg_wait` above 25 acts as 25.
- R6: When the wait count is nonzero, `bus_rdy_n` passes through two flops and is sampled in the last strobe cycle. While the sampled value is high, the strobe is held for one more cycle at a time.
- R7: When the wait count is 0, `bus_rdy_n` is ignored and the strobe lasts exactly one cycle.
- R8: Chip select stays low for `cfg_neg_dly` cycles after the strobe rises.
- R9: After chip select rises, the address is held for `cfg_hold` cycles. The acceptance-to-`done` latency is setup + delay + strobe + negate + hold + 1 cycles.
- R10: `bus_bs_n` falls with chip select. It stays low for 2 cycles when `cfg_bs_two` is set and the selected strobe delay is nonzero, and for 1 cycle otherwise.
- R11: Size encoding: `req_size` 0/1/2/3 means 1/2/4/8 bytes. Width encoding: `cfg_bus_w` 0/1/2/3 means 8/16/32/64 bits. The effective size is capped at the bus width. Write lanes start at `addr[2:0]`, aligned down to the effective size and reduced modulo the bus width in bytes. Only lanes inside the bus width are ever driven low.
- R12: With `cfg_burst_rom` set, a read runs 4 strobe beats under one chip select. Beats are separated by `cfg_pitch` cycles with the strobe high. The address steps by the bus width in bytes, and each beat's data appears with a `rd_beat_valid` pulse.
- R13: A read captures `bus_din` at the end of each beat into `rd_data`. A write drives `req_wdata` on `bus_dout` with `bus_doe` high. Read and write strobes are never low together, and a strobe is low only under chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write data, lane-placed |
| done | output | 1 | One-cycle completion pulse |
| rd_beat_valid | output | 1 | Read beat data valid |
| rd_data | output | 64 | Read beat data |
| cfg_area | input | 3 | Area code matched against address bits 28:26 |
| cfg_bus_w | input | 2 | Bus width code |
| cfg_setup | input | 3 | Address setup cycles |
| cfg_rd_dly | input | 3 | Chip select to read strobe delay |
| cfg_wr_dly | input | 3 | Chip select to write strobe delay |
| cfg_wait | input | 5 | Inserted wait cycles |
| cfg_neg_dly | input | 3 | Strobe release to chip select release delay |
| cfg_hold | input | 3 | Address hold cycles |
| cfg_bs_two | input | 1 | Request a two-cycle bus-start pulse |
| cfg_burst_rom | input | 1 | Burst-ROM read mode |
| cfg_pitch | input | 3 | Cycles between burst beats |
| bus_addr | output | 29 | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe / output enable, active low |
| bus_we_n | output | 8 | Byte write strobes, active low |
| bus_bs_n | output | 1 | Bus-start pulse, active low |
| bus_dout | output | 64 | Write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 64 | Read data from memory |
| bus_rdy_n | input | 1 | Memory ready, active low |

## Verification
The hardest case to reach is a strobe stretched by the ready input. The stretch happens only after the programmed waits have run out, and only after the ready level has crossed the two-flop synchronizer. The bench holds `bus_rdy_n` high before issuing a read with waits. It counts strobe cycles at the pins and releases ready on a chosen strobe cycle, so the extension length follows exactly from the synchronizer depth. The same high level is then applied with zero waits to show that it is ignored.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LEAD,
    PH_STROBE,
    PH_PITCH,
    PH_TRAIL,
    PH_HOLD
  } phase_e;

  // chip select is active in every phase between setup and hold
  function automatic logic cs_phase(input phase_e p);
    return (p == PH_LEAD) || (p == PH_STROBE) || (p == PH_PITCH) || (p == PH_TRAIL);
  endfunction

endpackage

// File: rtl/sram_sync2.sv
module sram_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/sram_lane_gen.sv
module sram_lane_gen #(
  parameter int LANES = 8
) (
  input  logic [$clog2(LANES)-1:0] addr_lo,
  input  logic [1:0]               size,
  input  logic [1:0]               bus_w,
  output logic [LANES-1:0]         mask
);
  localparam int OFF_W = $clog2(LANES);
  localparam int LW    = OFF_W + 1;

  logic [1:0]    eff_size;
  logic [LW-1:0] n_bytes;
  logic [LW-1:0] b_bytes;
  logic [LW-1:0] offset;

  always_comb begin
    eff_size = (size > bus_w) ? bus_w : size;
    n_bytes  = LW'(1) << eff_size;
    b_bytes  = LW'(1) << bus_w;
    offset   = {1'b0, addr_lo} & ~(n_bytes - LW'(1)) & (b_bytes - LW'(1));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (LW'(i) >= offset) && (LW'(i) < (offset + n_bytes)) && (LW'(i) < b_bytes);
  end
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctl_pkg::*;
#(
  parameter int MAX_WAIT = 25,
  parameter int BEATS    = 4,
  parameter int CNT_W    = $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             burst,
  input  logic [2:0]       setup_len,
  input  logic [2:0]       rd_dly,
  input  logic [2:0]       wr_dly,
  input  logic [CNT_W-1:0] wait_len,
  input  logic [2:0]       neg_len,
  input  logic [2:0]       hold_len,
  input  logic [2:0]       pitch_len,
  input  logic             bs_two,
  input  logic             rdy_wait_n,
  output phase_e           phase_o,
  output logic             strobe_end_o,
  output logic             step_o,
  output logic             finish_o,
  output logic             bs_active_o
);
  localparam int BEAT_W = $clog2(BEATS + 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [1:0]        bs_q, bs_d;

  logic [2:0]       dly;
  logic [CNT_W-1:0] w_eff;
  logic             last_beat;
  logic             strb_exit;
  phase_e           lead_ph;
  logic [CNT_W-1:0] lead_cnt;

  always_comb begin
    dly       = is_write ? wr_dly : rd_dly;
    w_eff     = (wait_len > CNT_W'(MAX_WAIT)) ? CNT_W'(MAX_WAIT) : wait_len;
    last_beat = !burst || (beat_q == BEAT_W'(BEATS - 1));
    strb_exit = (phase_q == PH_STROBE) && (cnt_q == '0) && !((w_eff != '0) && rdy_wait_n);
    if (dly != 3'd0) begin
      lead_ph  = PH_LEAD;
      lead_cnt = CNT_W'(dly) - CNT_W'(1);
    end else begin
      lead_ph  = PH_STROBE;
      lead_cnt = w_eff;
    end
  end

  // next-state process
  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    beat_d   = beat_q;
    finish_o = 1'b0;
    step_o   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          beat_d = '0;
          if (setup_len != 3'd0) begin
            phase_d = PH_SETUP;
            cnt_d   = CNT_W'(setup_len) - CNT_W'(1);
          end else begin
            phase_d = lead_ph;
            cnt_d   = lead_cnt;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = lead_ph;
          cnt_d   = lead_cnt;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_LEAD: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = w_eff;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (strb_exit) begin
          if (!last_beat) begin
            beat_d = beat_q + BEAT_W'(1);
            step_o = 1'b1;
            if (pitch_len != 3'd0) begin
              phase_d = PH_PITCH;
              cnt_d   = CNT_W'(pitch_len) - CNT_W'(1);
            end else begin
              phase_d = PH_STROBE;
              cnt_d   = w_eff;
            end
          end else if (neg_len != 3'd0) begin
            phase_d = PH_TRAIL;
            cnt_d   = CNT_W'(neg_len) - CNT_W'(1);
          end else if (hold_len != 3'd0) begin
            phase_d = PH_HOLD;
            cnt_d   = CNT_W'(hold_len) - CNT_W'(1);
          end else begin
            phase_d  = PH_IDLE;
            finish_o = 1'b1;
          end
        end
      end
      PH_PITCH: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = w_eff;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_TRAIL: begin
        if (cnt_q == '0) begin
          if (hold_len != 3'd0) begin
            phase_d = PH_HOLD;
            cnt_d   = CNT_W'(hold_len) - CNT_W'(1);
          end else begin
            phase_d  = PH_IDLE;
            finish_o = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d  = PH_IDLE;
          finish_o = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // bus-start length counter, loaded when chip select is about to fall
  always_comb begin
    bs_d = bs_q;
    if (cs_phase(phase_d) && !cs_phase(phase_q)) begin
      bs_d = (bs_two && (dly != 3'd0)) ? 2'd2 : 2'd1;
    end else if (bs_q != 2'd0) begin
      bs_d = bs_q - 2'd1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      bs_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      bs_q    <= bs_d;
    end
  end

  assign phase_o      = phase_q;
  assign strobe_end_o = strb_exit;
  assign bs_active_o  = (bs_q != 2'd0);

  // R10
  bs_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_q != 2'd0) |-> cs_phase(phase_q));

  // R7
  wait0_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && cnt_q == '0 && w_eff == '0)
      |=> (phase_q != PH_STROBE || beat_q != $past(beat_q)));

  // R6
  rdy_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && cnt_q == '0 && w_eff != '0 && rdy_wait_n)
      |=> (phase_q == PH_STROBE && cnt_q == '0));
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int DATA_W   = 64,
  parameter int MAX_WAIT = 25,
  parameter int BEATS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              rd_beat_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [2:0]        cfg_area,
  input  logic [1:0]        cfg_bus_w,
  input  logic [2:0]        cfg_setup,
  input  logic [2:0]        cfg_rd_dly,
  input  logic [2:0]        cfg_wr_dly,
  input  logic [4:0]        cfg_wait,
  input  logic [2:0]        cfg_neg_dly,
  input  logic [2:0]        cfg_hold,
  input  logic              cfg_bs_two,
  input  logic              cfg_burst_rom,
  input  logic [2:0]        cfg_pitch,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic [7:0]        bus_we_n,
  output logic              bus_bs_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_rdy_n
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int LW    = OFF_W + 1;
  localparam int CNT_W = $clog2(MAX_WAIT + 1);

  logic rst_int_n;
  logic rdy_wait_n;

  sram_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  sram_sync2 #(.RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .arst_n(rst_int_n), .d(bus_rdy_n), .q(rdy_wait_n)
  );

  phase_e             phase;
  logic               strobe_end, step, finish, bs_active;
  logic               idle, hit, accept, start;
  logic               seq_write, seq_burst;
  logic [LANES-1:0]   lane_mask;

  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic [LANES-1:0]   mask_q, mask_d;
  logic               write_q, write_d;
  logic               burst_q, burst_d;
  logic               done_q, done_d;
  logic               beat_v_q, beat_v_d;
  logic [ADDR_W-1:0]  bus_step;

  assign idle      = (phase == PH_IDLE);
  assign hit       = (req_addr[ADDR_W-1 -: 3] == cfg_area);
  assign req_ready = idle && !done_q;
  assign accept    = req_valid && req_ready;
  assign start     = accept && hit;
  assign seq_write = idle ? req_write : write_q;
  assign seq_burst = idle ? (cfg_burst_rom && !req_write) : burst_q;
  assign bus_step  = ADDR_W'(LW'(1) << cfg_bus_w);

  sram_lane_gen #(.LANES(LANES)) u_lanes (
    .addr_lo(req_addr[OFF_W-1:0]),
    .size   (req_size),
    .bus_w  (cfg_bus_w),
    .mask   (lane_mask)
  );

  sram_phase_seq #(.MAX_WAIT(MAX_WAIT), .BEATS(BEATS), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .is_write    (seq_write),
    .burst       (seq_burst),
    .setup_len   (cfg_setup),
    .rd_dly      (cfg_rd_dly),
    .wr_dly      (cfg_wr_dly),
    .wait_len    (CNT_W'(cfg_wait)),
    .neg_len     (cfg_neg_dly),
    .hold_len    (cfg_hold),
    .pitch_len   (cfg_pitch),
    .bs_two      (cfg_bs_two),
    .rdy_wait_n  (rdy_wait_n),
    .phase_o     (phase),
    .strobe_end_o(strobe_end),
    .step_o      (step),
    .finish_o    (finish),
    .bs_active_o (bs_active)
  );

  // next-state process
  always_comb begin
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    mask_d   = mask_q;
    write_d  = write_q;
    burst_d  = burst_q;
    rdata_d  = rdata_q;
    if (start) begin
      addr_d  = req_addr;
      wdata_d = req_wdata;
      mask_d  = req_write ? lane_mask : '0;
      write_d = req_write;
      burst_d = cfg_burst_rom && !req_write;
    end else if (step) begin
      addr_d = addr_q + bus_step;
    end
    if (strobe_end && !write_q) begin
      rdata_d = bus_din;
    end
    beat_v_d = strobe_end && !write_q;
    done_d   = finish || (accept && !hit);
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      write_q  <= 1'b0;
      burst_q  <= 1'b0;
      rdata_q  <= '0;
      beat_v_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      wdata_q  <= wdata_d;
      mask_q   <= mask_d;
      write_q  <= write_d;
      burst_q  <= burst_d;
      rdata_q  <= rdata_d;
      beat_v_q <= beat_v_d;
      done_q   <= done_d;
    end
  end

  assign bus_addr      = addr_q;
  assign bus_cs_n      = !cs_phase(phase);
  assign bus_rd_n      = !((phase == PH_STROBE) && !write_q);
  assign bus_we_n      = ((phase == PH_STROBE) && write_q) ? ~mask_q : '1;
  assign bus_bs_n      = !bs_active;
  assign bus_dout      = wdata_q;
  assign bus_doe       = write_q && !idle;
  assign done          = done_q;
  assign rd_beat_valid = beat_v_q;
  assign rd_data       = rdata_q;

  logic [LANES-1:0] lane_ok;
  assign lane_ok = ~({LANES{1'b1}} << (LW'(1) << cfg_bus_w));

  // R2
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ready |-> (bus_cs_n && bus_rd_n && (bus_we_n == '1)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R11
  lane_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((~bus_we_n) & ~lane_ok) == '0);

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!bus_rd_n && (bus_we_n != '1)));

  // R13
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!bus_rd_n || (bus_we_n != '1)) |-> !bus_cs_n);
endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [28:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic        done, rd_beat_valid;
  logic [63:0] rd_data;
  logic [2:0]  cfg_area, cfg_setup, cfg_rd_dly, cfg_wr_dly, cfg_neg_dly, cfg_hold, cfg_pitch;
  logic [1:0]  cfg_bus_w;
  logic [4:0]  cfg_wait;
  logic        cfg_bs_two, cfg_burst_rom;
  logic [28:0] bus_addr;
  logic        bus_cs_n, bus_rd_n, bus_bs_n, bus_doe;
  logic [7:0]  bus_we_n;
  logic [63:0] bus_dout, bus_din;
  logic        bus_rdy_n;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign bus_din = {35'd0, bus_addr};

  sram_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .done(done), .rd_beat_valid(rd_beat_valid), .rd_data(rd_data),
    .cfg_area(cfg_area), .cfg_bus_w(cfg_bus_w), .cfg_setup(cfg_setup),
    .cfg_rd_dly(cfg_rd_dly), .cfg_wr_dly(cfg_wr_dly), .cfg_wait(cfg_wait),
    .cfg_neg_dly(cfg_neg_dly), .cfg_hold(cfg_hold), .cfg_bs_two(cfg_bs_two),
    .cfg_burst_rom(cfg_burst_rom), .cfg_pitch(cfg_pitch),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_bs_n(bus_bs_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // results of one transaction, measured at the pins
  int          t_total, t_cs, t_strb, t_bs, t_pre, t_beats, t_ready_bad, t_dout_bad;
  logic [7:0]  t_we;
  logic [63:0] t_rd [4];

  task automatic run_txn(input logic wr, input logic [28:0] addr, input logic [1:0] size,
                         input logic [63:0] wd, input int rdy_rel);
    t_total = 0; t_cs = 0; t_strb = 0; t_bs = 0; t_pre = -1; t_beats = 0;
    t_ready_bad = 0; t_dout_bad = 0; t_we = 8'hFF;
    for (int k = 0; k < 4; k++) t_rd[k] = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = wd;
    if (!req_ready) t_ready_bad++;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      t_total++;
      if (!bus_cs_n) begin
        if (t_cs == 0) t_pre = t_total - 1;
        t_cs++;
      end
      if (!bus_rd_n || bus_we_n != 8'hFF) begin
        t_strb++;
        t_we = t_we & bus_we_n;
        if (wr && (!bus_doe || bus_dout != wd)) t_dout_bad++;
        if (rdy_rel != 0 && t_strb == rdy_rel) bus_rdy_n = 1'b0;
      end
      if (!bus_bs_n) t_bs++;
      if (rd_beat_valid) begin
        if (t_beats < 4) t_rd[t_beats] = rd_data;
        t_beats++;
      end
      if (req_ready != done) begin
        // ready must be low throughout, including the done cycle
        if (req_ready) t_ready_bad++;
      end
      if (done) begin
        if (req_ready) t_ready_bad++;
        break;
      end
    end
  endtask

  typedef struct packed {
    logic       wr;
    logic [2:0] alo;
    logic [1:0] size;
    logic [1:0] busw;
    logic [2:0] s;
    logic [2:0] d;
    logic [4:0] w;
    logic [2:0] n;
    logic [2:0] h;
    logic       bs2;
    logic [5:0] e_total;
    logic [5:0] e_cs;
    logic [5:0] e_strb;
    logic [1:0] e_bs;
    logic [7:0] e_we;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 3'd0, 2'd2, 2'd2, 3'd0, 3'd0, 5'd0,  3'd0, 3'd0, 1'b1, 6'd2,  6'd1,  6'd1,  2'd1, 8'hFF},
    '{1'b1, 3'd3, 2'd0, 2'd2, 3'd1, 3'd2, 5'd3,  3'd1, 3'd2, 1'b1, 6'd11, 6'd7,  6'd4,  2'd2, 8'hF7},
    '{1'b1, 3'd4, 2'd2, 2'd1, 3'd7, 3'd7, 5'd0,  3'd7, 3'd7, 1'b0, 6'd30, 6'd15, 6'd1,  2'd1, 8'hFC},
    '{1'b0, 3'd0, 2'd2, 2'd2, 3'd2, 3'd1, 5'd25, 3'd0, 3'd1, 1'b1, 6'd31, 6'd27, 6'd26, 2'd2, 8'hFF},
    '{1'b1, 3'd0, 2'd3, 2'd3, 3'd0, 3'd0, 5'd1,  3'd3, 3'd0, 1'b1, 6'd6,  6'd5,  6'd2,  2'd1, 8'h00},
    '{1'b1, 3'd1, 2'd1, 2'd0, 3'd3, 3'd0, 5'd0,  3'd0, 3'd3, 1'b0, 6'd8,  6'd1,  6'd1,  2'd1, 8'hFE},
    '{1'b1, 3'd6, 2'd1, 2'd3, 3'd0, 3'd3, 5'd2,  3'd2, 3'd0, 1'b1, 6'd9,  6'd8,  6'd3,  2'd2, 8'h3F},
    '{1'b0, 3'd0, 2'd2, 2'd2, 3'd0, 3'd0, 5'd31, 3'd0, 3'd0, 1'b0, 6'd27, 6'd26, 6'd26, 2'd1, 8'hFF}
  };

  task automatic set_cfg(input logic [1:0] bw, input logic [2:0] s, input logic [2:0] rd,
                         input logic [2:0] wrd, input logic [4:0] w, input logic [2:0] n,
                         input logic [2:0] h, input logic bs2, input logic brom,
                         input logic [2:0] p);
    cfg_bus_w = bw; cfg_setup = s; cfg_rd_dly = rd; cfg_wr_dly = wrd; cfg_wait = w;
    cfg_neg_dly = n; cfg_hold = h; cfg_bs_two = bs2; cfg_burst_rom = brom; cfg_pitch = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [28:0] a;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_wdata = '0; bus_rdy_n = 1'b0; cfg_area = 3'b010;
    set_cfg(2'd2, 3'd0, 3'd0, 3'd0, 5'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R2)
    check("R2 reset cs_n", longint'(bus_cs_n), 1);
    check("R2 reset rd_n", longint'(bus_rd_n), 1);
    check("R2 reset we_n", longint'(bus_we_n), 8'hFF);
    check("R2 reset bs_n", longint'(bus_bs_n), 1);
    check("R2 reset ready", longint'(req_ready), 1);
    check("R2 reset done", longint'(done), 0);

    // table of single-cycle accesses
    for (int v = 0; v < NVEC; v++) begin
      vec_t x;
      logic [63:0] wd;
      x  = VECS[v];
      wd = 64'h0123_4567_89AB_CDEF ^ 64'(v);
      a  = {3'b010, 23'h01234, x.alo};
      if (x.wr) set_cfg(x.busw, x.s, 3'd5, x.d, x.w, x.n, x.h, x.bs2, 1'b0, 3'd0);
      else      set_cfg(x.busw, x.s, x.d, 3'd5, x.w, x.n, x.h, x.bs2, 1'b0, 3'd0);
      run_txn(x.wr, a, x.size, wd, 0);
      check("R9 total latency", t_total, longint'(x.e_total));
      check("R3 setup cycles", t_pre, longint'(x.s));
      check("R4 R8 cs low cycles", t_cs, longint'(x.e_cs));
      check("R5 strobe cycles", t_strb, longint'(x.e_strb));
      check("R10 bs cycles", t_bs, longint'(x.e_bs));
      check("R11 write lanes", longint'(t_we), longint'(x.e_we));
      check("R2 ready during txn", t_ready_bad, 0);
      if (x.wr) check("R13 write data", t_dout_bad, 0);
      else begin
        check("R13 read beats", t_beats, 1);
        check("R13 read data", longint'(t_rd[0]), longint'({35'd0, a}));
      end
    end

    // R1 area miss
    set_cfg(2'd2, 3'd2, 3'd1, 3'd1, 5'd3, 3'd1, 3'd1, 1'b1, 1'b0, 3'd0);
    run_txn(1'b1, {3'b011, 26'h0000040}, 2'd2, 64'hDEAD, 0);
    check("R1 miss latency", t_total, 1);
    check("R1 miss no cs", t_cs, 0);
    check("R1 miss no strobe", t_strb, 0);

    // R6 ready stretches the strobe: waits=2, ready released on strobe cycle 10
    set_cfg(2'd2, 3'd0, 3'd0, 3'd0, 5'd2, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0);
    bus_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    run_txn(1'b0, {3'b010, 26'h0000100}, 2'd2, '0, 10);
    check("R6 stretched strobe", t_strb, 12);
    check("R6 stretched latency", t_total, 13);

    // R7 ready ignored with zero waits
    set_cfg(2'd2, 3'd0, 3'd0, 3'd0, 5'd0, 3'd0, 3'd0, 1'b0, 1'b0, 3'd0);
    bus_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    run_txn(1'b0, {3'b010, 26'h0000200}, 2'd2, '0, 0);
    check("R7 strobe with ready high", t_strb, 1);
    check("R7 latency with ready high", t_total, 2);
    bus_rdy_n = 1'b0;
    repeat (3) @(negedge clk);

    // R12 burst with pitch 2 on 32-bit bus
    set_cfg(2'd2, 3'd1, 3'd1, 3'd0, 5'd1, 3'd1, 3'd1, 1'b1, 1'b1, 3'd2);
    a = {3'b010, 26'h0000040};
    run_txn(1'b0, a, 2'd2, '0, 0);
    check("R12 burst strobe cycles", t_strb, 8);
    check("R12 burst cs cycles", t_cs, 16);
    check("R12 burst latency", t_total, 19);
    check("R12 burst beats", t_beats, 4);
    check("R10 burst bs cycles", t_bs, 2);
    for (int k = 0; k < 4; k++)
      check("R12 burst beat data", longint'(t_rd[k]), longint'({35'd0, a + 29'(4 * k)}));

    // R12 burst with pitch 0 on 64-bit bus
    set_cfg(2'd3, 3'd0, 3'd0, 3'd0, 5'd0, 3'd0, 3'd0, 1'b0, 1'b1, 3'd0);
    a = {3'b010, 26'h0000080};
    run_txn(1'b0, a, 2'd3, '0, 0);
    check("R12 tight burst strobe", t_strb, 4);
    check("R12 tight burst latency", t_total, 5);
    check("R12 tight burst beats", t_beats, 4);
    check("R12 tight burst last data", longint'(t_rd[3]), longint'({35'd0, a + 29'd24}));

    // R12 writes stay single in burst mode
    run_txn(1'b1, a, 2'd3, 64'h55, 0);
    check("R12 write not burst", t_strb, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule